// File: doc/BRIEF.md
# Out-of-order issue scheduler with operand wakeup

This block is the scheduling buffer between dispatch and the execution pipelines of an out-of-order core. Each entry holds one dispatched instruction: its result tag, the resource group it needs, a fixed execution latency and up to `NSRC` source tags. An entry is free, waiting for operands, ready, or issued. Waiting entries watch two broadcast sources: an external result-tag bus and the tags of entries of its own that finish execution in the current cycle. When every source is satisfied they become ready.

Every cycle each resource group can issue one instruction. The oldest ready instruction of the group wins, and a unit of the group is chosen by a round-robin pointer that skips busy pipelines. An issued entry counts its latency down, broadcasts its tag when the count expires, is freed and raises a completion notice for the retire logic. A full flag tells the dispatch stage that no entry is free.

Top module: `oiq_sched`

## Requirements
- R1: A dispatched instruction whose sources are all marked available, or whose pending source tags all match a broadcast in the dispatch cycle, is eligible the next cycle. One with any other pending source enters the waiting state and does not issue.
- R2: A waiting entry whose last pending source matches `wake_tag` with `wake_valid` high in cycle w issues no earlier than cycle w+2, and exactly then when its group has a free unit and no older ready entry.
- R3: An instruction dispatched in cycle d appears on the issue outputs no earlier than cycle d+2; with no contention it appears exactly in d+2.
- R4: Within one resource group at most one instruction issues per cycle, and among ready entries of that group the one dispatched earliest is always chosen first.
- R5: For group g, `iss_unit[g*UW +: UW]` gives the unit within the group. The unit is the first non-busy one found starting from a per-group pointer and counting upward with wrap; the pointer moves to the unit after the chosen one only when that group issues. All pointers start at unit 0.
- R6: A pipeline whose `pipe_busy` bit, at index group*NUNIT+unit, is high in the selection cycle is never granted; when all units of a group are busy, that group issues nothing.
- R7: An instruction on the issue outputs in cycle i with latency L raises its slot bit in `ret_valid`, with its tag in `ret_tag[slot*TAGW +: TAGW]`, in cycle i+L, exactly once; a latency of 0 counts as 1.
- R8: An entry waiting on the result tag of another entry in the buffer issues in the cycle after that producer's completion notice, when no other condition holds it back.
- R9: `full` is high while every entry is occupied; a dispatch presented while `full` is high is dropped and never issues.
- R10: After reset all entries are free: `full`, `iss_valid` and `ret_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_tag | input | TAGW | Result tag of the dispatched instruction |
| disp_grp | input | GRPW | Resource group index |
| disp_lat | input | LATW | Execution latency in cycles (0 treated as 1) |
| disp_src_tag | input | NSRC*TAGW | Source tags, source s at bits s*TAGW |
| disp_src_wait | input | NSRC | Bit s high: source s not yet produced |
| wake_valid | input | 1 | External result broadcast valid |
| wake_tag | input | TAGW | External result tag |
| pipe_busy | input | NGRP*NUNIT | Busy flag per pipeline, bit group*NUNIT+unit |
| full | output | 1 | All entries occupied |
| iss_valid | output | NGRP | Group g issued this cycle |
| iss_unit | output | NGRP*UW | Unit chosen per group |
| iss_tag | output | NGRP*TAGW | Tag issued per group |
| ret_valid | output | ENTRIES | Completion notice per slot |
| ret_tag | output | ENTRIES*TAGW | Tag of the completing instruction per slot |

## Verification
Every result comes through a registered output, so a dispatch or broadcast sampled at the end of cycle c can change state for cycle c+1, and the resulting grant is seen on the issue outputs in c+2; completion notices follow the issue output by exactly the latency, and a dependant issues one cycle after its producer's notice. The bench drives inputs just after a rising edge, logs every issue and completion with the cycle number at the falling edge, and compares the logged cycles and units against those offsets, computed per instruction from its own dispatch, broadcast or busy-release cycle. Busy flags are logged per cycle so that a grant can be checked against the busy state of the cycle before it appeared.

// File: rtl/oiq_pkg.sv
package oiq_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_READY  = 2'd2,
    SLOT_ISSUED = 2'd3
  } slot_state_e;
endpackage

// File: rtl/oiq_age_pick.sv
// Age matrix: older_q[j][i] set when slot j was allocated before slot i.
// Picks, per group, the oldest requesting slot.
module oiq_age_pick #(
  parameter int N    = 8,
  parameter int G    = 2,
  parameter int IDXW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDXW-1:0]  alloc_idx,
  input  logic [N-1:0]     occupied,
  input  logic [G*N-1:0]   req,
  output logic [G*N-1:0]   gnt
);
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N; j++) older_q[j] <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < N; j++)
        older_q[j][alloc_idx] <= occupied[j] && (alloc_idx != IDXW'(j));
      older_q[alloc_idx] <= '0;
    end
  end

  always_comb begin
    for (int g = 0; g < G; g++) begin
      for (int i = 0; i < N; i++) begin
        logic blocked;
        blocked = 1'b0;
        for (int j = 0; j < N; j++)
          if (req[g*N+j] && older_q[j][i]) blocked = 1'b1;
        gnt[g*N+i] = req[g*N+i] && !blocked;
      end
    end
  end
endmodule

// File: rtl/oiq_unit_rr.sv
// Round-robin unit chooser for one resource group.
module oiq_unit_rr #(
  parameter int NUNIT = 2,
  parameter int UW    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUNIT-1:0] busy,
  input  logic             adv,
  output logic             any_free,
  output logic [UW-1:0]    pick
);
  logic [UW-1:0] ptr_q;

  always_comb begin
    any_free = 1'b0;
    pick     = ptr_q;
    for (int k = NUNIT - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUNIT;
      if (!busy[idx]) begin
        any_free = 1'b1;
        pick     = UW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (adv) ptr_q <= (int'(pick) == NUNIT - 1) ? '0 : pick + UW'(1);
  end
endmodule

// File: rtl/oiq_sched.sv
module oiq_sched #(
  parameter int ENTRIES = 8,
  parameter int TAGW    = 6,
  parameter int NSRC    = 2,
  parameter int NGRP    = 2,
  parameter int NUNIT   = 2,
  parameter int LATW    = 3,
  parameter int GRPW    = (NGRP > 1) ? $clog2(NGRP) : 1,
  parameter int UW      = (NUNIT > 1) ? $clog2(NUNIT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     disp_valid,
  input  logic [TAGW-1:0]          disp_tag,
  input  logic [GRPW-1:0]          disp_grp,
  input  logic [LATW-1:0]          disp_lat,
  input  logic [NSRC*TAGW-1:0]     disp_src_tag,
  input  logic [NSRC-1:0]          disp_src_wait,
  input  logic                     wake_valid,
  input  logic [TAGW-1:0]          wake_tag,
  input  logic [NGRP*NUNIT-1:0]    pipe_busy,
  output logic                     full,
  output logic [NGRP-1:0]          iss_valid,
  output logic [NGRP*UW-1:0]       iss_unit,
  output logic [NGRP*TAGW-1:0]     iss_tag,
  output logic [ENTRIES-1:0]       ret_valid,
  output logic [ENTRIES*TAGW-1:0]  ret_tag
);
  import oiq_pkg::*;

  localparam int IDXW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Entry storage
  slot_state_e       st_q   [ENTRIES];
  logic [TAGW-1:0]   tag_q  [ENTRIES];
  logic [GRPW-1:0]   grp_q  [ENTRIES];
  logic [LATW-1:0]   lat_q  [ENTRIES];
  logic [LATW-1:0]   cnt_q  [ENTRIES];
  logic [TAGW-1:0]   srct_q [ENTRIES][NSRC];
  logic [NSRC-1:0]   srcw_q [ENTRIES];

  logic [ENTRIES-1:0]      occupied, comp, issued_now;
  logic [NSRC-1:0]         srcw_n [ENTRIES];
  logic [NSRC-1:0]         dw_n;
  logic                    alloc_en;
  logic [IDXW-1:0]         alloc_idx;
  logic [NGRP*ENTRIES-1:0] req, gnt;
  logic [NGRP-1:0]         unit_free, sel_any;
  logic [UW-1:0]           unit_pick [NGRP];
  logic [TAGW-1:0]         sel_tag   [NGRP];
  logic [2*ENTRIES-1:0]    st_flat;

  // Output registers
  logic [NGRP-1:0]         iss_valid_q;
  logic [NGRP*UW-1:0]      iss_unit_q;
  logic [NGRP*TAGW-1:0]    iss_tag_q;
  logic [ENTRIES-1:0]      ret_valid_q;
  logic [ENTRIES*TAGW-1:0] ret_tag_q;

  // Occupancy, completion and allocation slot
  always_comb begin
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      occupied[i] = (st_q[i] != SLOT_FREE);
      comp[i]     = (st_q[i] == SLOT_ISSUED) && (cnt_q[i] == LATW'(1));
      if (st_q[i] == SLOT_FREE) alloc_idx = IDXW'(i);
      st_flat[2*i +: 2] = st_q[i];
    end
  end

  assign full     = &occupied;
  assign alloc_en = disp_valid && !full;

  // Wakeup: external bus plus tags of entries finishing this cycle
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      for (int s = 0; s < NSRC; s++) begin
        logic hit;
        hit = wake_valid && (wake_tag == srct_q[i][s]);
        for (int j = 0; j < ENTRIES; j++)
          if (comp[j] && (tag_q[j] == srct_q[i][s])) hit = 1'b1;
        srcw_n[i][s] = srcw_q[i][s] && !hit;
      end
    end
    for (int s = 0; s < NSRC; s++) begin
      logic dhit;
      dhit = wake_valid && (wake_tag == disp_src_tag[s*TAGW +: TAGW]);
      for (int j = 0; j < ENTRIES; j++)
        if (comp[j] && (tag_q[j] == disp_src_tag[s*TAGW +: TAGW])) dhit = 1'b1;
      dw_n[s] = disp_src_wait[s] && !dhit;
    end
  end

  // Per-group unit choice
  genvar gg;
  generate
    for (gg = 0; gg < NGRP; gg++) begin : g_grp
      oiq_unit_rr #(.NUNIT(NUNIT), .UW(UW)) u_rr (
        .clk      (clk),
        .rst      (rst),
        .busy     (pipe_busy[gg*NUNIT +: NUNIT]),
        .adv      (sel_any[gg]),
        .any_free (unit_free[gg]),
        .pick     (unit_pick[gg])
      );
    end
  endgenerate

  // Requests: ready entries of a group with a free unit
  always_comb begin
    for (int g = 0; g < NGRP; g++)
      for (int i = 0; i < ENTRIES; i++)
        req[g*ENTRIES+i] = (st_q[i] == SLOT_READY) && (grp_q[i] == GRPW'(g)) && unit_free[g];
  end

  oiq_age_pick #(.N(ENTRIES), .G(NGRP), .IDXW(IDXW)) u_age (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (alloc_en),
    .alloc_idx (alloc_idx),
    .occupied  (occupied),
    .req       (req),
    .gnt       (gnt)
  );

  always_comb begin
    issued_now = '0;
    for (int g = 0; g < NGRP; g++) begin
      sel_any[g] = 1'b0;
      sel_tag[g] = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (gnt[g*ENTRIES+i]) begin
          sel_any[g]    = 1'b1;
          sel_tag[g]    = sel_tag[g] | tag_q[i];
          issued_now[i] = 1'b1;
        end
      end
    end
  end

  // Entry state machine (payload fields carry no reset)
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (alloc_en && (alloc_idx == IDXW'(i))) begin
        tag_q[i]  <= disp_tag;
        grp_q[i]  <= disp_grp;
        lat_q[i]  <= (disp_lat == '0) ? LATW'(1) : disp_lat;
        srcw_q[i] <= dw_n;
        for (int s = 0; s < NSRC; s++) srct_q[i][s] <= disp_src_tag[s*TAGW +: TAGW];
      end else if (st_q[i] == SLOT_WAIT) begin
        srcw_q[i] <= srcw_n[i];
      end
      if (!alloc_en || (alloc_idx != IDXW'(i))) begin
        if (st_q[i] == SLOT_READY && issued_now[i]) cnt_q[i] <= lat_q[i];
        else if (st_q[i] == SLOT_ISSUED && !comp[i]) cnt_q[i] <= cnt_q[i] - LATW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) st_q[i] <= SLOT_FREE;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_en && (alloc_idx == IDXW'(i))) begin
          st_q[i] <= (|dw_n) ? SLOT_WAIT : SLOT_READY;
        end else begin
          case (st_q[i])
            SLOT_WAIT:   if (srcw_n[i] == '0) st_q[i] <= SLOT_READY;
            SLOT_READY:  if (issued_now[i]) st_q[i] <= SLOT_ISSUED;
            SLOT_ISSUED: if (comp[i]) st_q[i] <= SLOT_FREE;
            default:     ;
          endcase
        end
      end
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid_q <= '0;
      iss_unit_q  <= '0;
      iss_tag_q   <= '0;
      ret_valid_q <= '0;
      ret_tag_q   <= '0;
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        iss_valid_q[g]              <= sel_any[g];
        iss_unit_q[g*UW +: UW]      <= unit_pick[g];
        iss_tag_q[g*TAGW +: TAGW]   <= sel_tag[g];
      end
      for (int i = 0; i < ENTRIES; i++) begin
        ret_valid_q[i]              <= comp[i];
        ret_tag_q[i*TAGW +: TAGW]   <= tag_q[i];
      end
    end
  end

  assign iss_valid = iss_valid_q;
  assign iss_unit  = iss_unit_q;
  assign iss_tag   = iss_tag_q;
  assign ret_valid = ret_valid_q;
  assign ret_tag   = ret_tag_q;
endmodule

// File: rtl/oiq_sched_chk.sv
module oiq_sched_chk #(
  parameter int ENTRIES = 8,
  parameter int NGRP    = 2,
  parameter int NUNIT   = 2,
  parameter int UW      = 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    full,
  input logic [NGRP*NUNIT-1:0]   pipe_busy,
  input logic [NGRP-1:0]         iss_valid,
  input logic [NGRP*UW-1:0]      iss_unit,
  input logic [ENTRIES-1:0]      ret_valid,
  input logic [ENTRIES-1:0]      comp_vec,
  input logic [2*ENTRIES-1:0]    st_flat
);
  logic [NGRP*NUNIT-1:0] busy_d;
  logic [NGRP-1:0]       iss_d;
  logic [NGRP*UW-1:0]    unit_d;
  logic [2*ENTRIES-1:0]  st_d;
  logic [ENTRIES-1:0]    comp_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_d <= '0; iss_d <= '0; unit_d <= '0; st_d <= '0; comp_d <= '0;
    end else begin
      busy_d <= pipe_busy; iss_d <= iss_valid; unit_d <= iss_unit;
      st_d <= st_flat; comp_d <= comp_vec;
    end
  end

  genvar g, i;
  generate
    for (g = 0; g < NGRP; g++) begin : g_chk
      logic [UW-1:0] u_now, u_prev, u_next;
      assign u_now  = iss_unit[g*UW +: UW];
      assign u_prev = unit_d[g*UW +: UW];
      assign u_next = (int'(u_prev) == NUNIT - 1) ? '0 : u_prev + UW'(1);

      assert_busy_free_R6: assert property (@(posedge clk) disable iff (rst)
        iss_valid[g] |-> !busy_d[g*NUNIT + int'(u_now)]);

      assert_rr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid[g] && iss_d[g] && busy_d[g*NUNIT +: NUNIT] == '0) |-> (u_now == u_next));
    end
    for (i = 0; i < ENTRIES; i++) begin : e_chk
      assert_no_fast_issue_R3: assert property (@(posedge clk) disable iff (rst)
        (st_flat[2*i +: 2] == 2'd3) |-> (st_d[2*i +: 2] != 2'd0));

      assert_ret_from_issued_R7: assert property (@(posedge clk) disable iff (rst)
        ret_valid[i] |-> (comp_d[i] && st_d[2*i +: 2] == 2'd3));
    end
  endgenerate

  assert_full_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (full && comp_vec == '0) |=> full);
endmodule

bind oiq_sched oiq_sched_chk #(
  .ENTRIES(ENTRIES), .NGRP(NGRP), .NUNIT(NUNIT), .UW(UW)
) u_chk (
  .clk(clk), .rst(rst), .full(full), .pipe_busy(pipe_busy),
  .iss_valid(iss_valid), .iss_unit(iss_unit), .ret_valid(ret_valid),
  .comp_vec(comp), .st_flat(st_flat)
);

// File: tb/oiq_sched_test.sv
`timescale 1ns/1ps
module oiq_sched_test;
  localparam int N = 8, TW = 6, NS = 2, NG = 2, NU = 2, LW = 3, GW = 1, UW = 1;
  localparam int MAXOP = 512;

  logic clk = 0, rst = 1;
  logic disp_valid = 0;
  logic [TW-1:0] disp_tag = '0;
  logic [GW-1:0] disp_grp = '0;
  logic [LW-1:0] disp_lat = '0;
  logic [NS*TW-1:0] disp_src_tag = '0;
  logic [NS-1:0] disp_src_wait = '0;
  logic wake_valid = 0;
  logic [TW-1:0] wake_tag = '0;
  logic [NG*NU-1:0] pipe_busy = '0;
  logic full;
  logic [NG-1:0] iss_valid;
  logic [NG*UW-1:0] iss_unit;
  logic [NG*TW-1:0] iss_tag;
  logic [N-1:0] ret_valid;
  logic [N*TW-1:0] ret_tag;

  oiq_sched uut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_ops = 0;
  bit done = 0;
  int op_tag[MAXOP], op_grp[MAXOP], op_lat[MAXOP], op_disp[MAXOP];
  int op_iss[MAXOP], op_unit[MAXOP], op_igrp[MAXOP], op_ret[MAXOP];
  int op_nis[MAXOP], op_nret[MAXOP];
  int tag2op[64];
  logic [NG*NU-1:0] busy_log[4096];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Monitor: log issues, completions and busy state per cycle
  always @(negedge clk) begin
    if (!rst) begin
      busy_log[cyc % 4096] = pipe_busy;
      for (int g = 0; g < NG; g++) begin
        if (iss_valid[g]) begin
          int id;
          id = tag2op[iss_tag[g*TW +: TW]];
          if (id >= 0) begin
            op_nis[id]++; op_iss[id] = cyc;
            op_unit[id] = int'(iss_unit[g*UW +: UW]); op_igrp[id] = g;
          end
        end
      end
      for (int i = 0; i < N; i++) begin
        if (ret_valid[i]) begin
          int id;
          id = tag2op[ret_tag[i*TW +: TW]];
          if (id >= 0) begin op_nret[id]++; op_ret[id] = cyc; end
        end
      end
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic disp(input int g, input int lat, input int tag, input bit w,
                      input int wt, output int id);
    id = n_ops++;
    op_tag[id] = tag; op_grp[id] = g; op_lat[id] = lat; op_disp[id] = cyc;
    op_iss[id] = -1; op_ret[id] = -1; op_nis[id] = 0; op_nret[id] = 0;
    tag2op[tag] = id;
    disp_valid = 1; disp_tag = TW'(tag); disp_grp = GW'(g); disp_lat = LW'(lat);
    disp_src_tag = {TW'(0), TW'(wt)}; disp_src_wait = {1'b0, w};
    step(1);
    disp_valid = 0; disp_src_wait = '0;
  endtask

  task automatic wake(input int t);
    wake_valid = 1; wake_tag = TW'(t);
    step(1);
    wake_valid = 0;
  endtask

  function automatic int eff_lat(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  int a, b, c, d, e, f, h, x, y, z, r, w;
  int t7[8];
  int drop_id, rstart;

  initial begin
    for (int i = 0; i < 64; i++) tag2op[i] = -1;
    void'($urandom(32'd24681));
    step(3);
    rst = 0;
    @(negedge clk);
    chk(full == 0, "R10 full after reset", full, 0);
    chk(iss_valid == 0, "R10 no issue after reset", iss_valid, 0);
    chk(ret_valid == 0, "R10 no retire after reset", ret_valid, 0);
    @(posedge clk); #1;

    // R1/R3/R7: single ready op
    disp(0, 2, 1, 0, 0, a);
    step(6);
    chk(op_iss[a] == op_disp[a] + 2, "R3 issue two cycles after dispatch", op_iss[a], op_disp[a] + 2);
    chk(op_unit[a] == 0, "R5 first unit", op_unit[a], 0);
    chk(op_ret[a] == op_iss[a] + 2, "R7 retire after latency", op_ret[a], op_iss[a] + 2);

    // R5: round robin across back-to-back ops
    disp(0, 1, 2, 0, 0, b); disp(0, 1, 3, 0, 0, c); disp(0, 1, 4, 0, 0, d);
    step(6);
    chk(op_unit[b] == 1, "R5 rr unit b", op_unit[b], 1);
    chk(op_unit[c] == 0, "R5 rr unit c", op_unit[c], 0);
    chk(op_unit[d] == 1, "R5 rr unit d", op_unit[d], 1);
    chk(op_iss[d] == op_disp[d] + 2, "R3 pipelined issue", op_iss[d], op_disp[d] + 2);

    // R6: busy unit skipped, all busy blocks group
    pipe_busy = 4'b0001;
    disp(0, 1, 5, 0, 0, e);
    step(4);
    chk(op_unit[e] == 1, "R6 busy unit skipped", op_unit[e], 1);
    pipe_busy = 4'b0011;
    disp(0, 1, 6, 0, 0, f);
    step(4);
    chk(op_nis[f] == 0, "R6 all busy no issue", op_nis[f], 0);
    pipe_busy = 4'b0000; r = cyc;
    step(4);
    chk(op_iss[f] == r + 1, "R6 issue after release", op_iss[f], r + 1);
    chk(op_unit[f] == 0, "R5 pointer held while blocked", op_unit[f], 0);

    // R2: external wake
    disp(0, 1, 7, 1, 40, h);
    step(3);
    chk(op_nis[h] == 0, "R1 waiting op not issued", op_nis[h], 0);
    w = cyc;
    wake(40);
    step(4);
    chk(op_iss[h] == w + 2, "R2 issue two cycles after wake", op_iss[h], w + 2);

    // R8: internal wake from completing producer
    disp(1, 3, 8, 0, 0, x);
    disp(1, 1, 9, 1, 8, y);
    step(10);
    chk(op_ret[x] == op_iss[x] + 3, "R7 producer latency", op_ret[x], op_iss[x] + 3);
    chk(op_iss[y] == op_ret[x] + 1, "R8 dependant after producer notice", op_iss[y], op_ret[x] + 1);

    // R4: oldest first, waking old entry beats younger ready ones
    pipe_busy = 4'b1100;
    disp(1, 1, 13, 1, 50, z);
    disp(1, 1, 10, 0, 0, a);
    disp(1, 1, 11, 0, 0, b);
    disp(1, 1, 12, 0, 0, c);
    wake(50);
    pipe_busy = 4'b1000; r = cyc;
    step(8);
    chk(op_iss[z] == r + 1, "R4 oldest first", op_iss[z], r + 1);
    chk(op_iss[a] == r + 2, "R4 order second", op_iss[a], r + 2);
    chk(op_iss[b] == r + 3, "R4 order third", op_iss[b], r + 3);
    chk(op_iss[c] == r + 4, "R4 order fourth", op_iss[c], r + 4);
    chk(op_unit[c] == 0, "R6 only free unit", op_unit[c], 0);
    pipe_busy = 4'b0000;
    step(4);

    // R7: zero latency treated as one
    disp(0, 0, 21, 0, 0, d);
    step(5);
    chk(op_ret[d] == op_iss[d] + 1, "R7 zero latency", op_ret[d], op_iss[d] + 1);

    // R1: wake in the dispatch cycle
    wake_valid = 1; wake_tag = TW'(55);
    disp(1, 1, 22, 1, 55, e);
    wake_valid = 0;
    step(4);
    chk(op_iss[e] == op_disp[e] + 2, "R1 same-cycle wake at dispatch", op_iss[e], op_disp[e] + 2);

    // R9: fill, dropped dispatch, drain
    pipe_busy = 4'b1111;
    for (int k = 0; k < 8; k++) disp(k % 2, 2, (k < 6) ? 14 + k : 17 + k, 0, 0, t7[k]);
    @(negedge clk);
    chk(full == 1, "R9 full when all occupied", full, 1);
    @(posedge clk); #1;
    disp(0, 1, 20, 0, 0, drop_id);
    pipe_busy = 4'b0000;
    step(20);
    chk(full == 0, "R9 full clears after drain", full, 0);
    chk(op_nis[drop_id] == 0, "R9 dropped dispatch never issues", op_nis[drop_id], 0);
    for (int k = 0; k < 8; k++)
      chk(op_nret[t7[k]] == 1, "R9 buffered ops complete", op_nret[t7[k]], 1);

    // Random phase: ready ops, random busy, random noise on wake bus
    rstart = n_ops;
    for (int t = 0; t < 400; t++) begin
      int infl, tg, pid, id;
      infl = 0;
      for (int k = rstart; k < n_ops; k++) if (op_nret[k] == 0) infl++;
      for (int p = 0; p < NG*NU; p++) pipe_busy[p] = ($urandom % 4 == 0);
      wake_valid = $urandom % 2; wake_tag = TW'(1 + $urandom % 12);
      tg = 30 + (n_ops % 34);
      pid = tag2op[tg];
      if (($urandom % 10 < 6) && infl < 6 && (pid < 0 || op_nret[pid] > 0))
        disp($urandom % 2, $urandom % 8, tg, 0, 0, id);
      else step(1);
    end
    wake_valid = 0; pipe_busy = '0;
    step(30);
    for (int k = rstart; k < n_ops; k++) begin
      chk(op_nis[k] == 1 && op_nret[k] == 1, "R7 random issue and retire once", op_nret[k], 1);
      chk(op_ret[k] == op_iss[k] + eff_lat(op_lat[k]), "R7 random latency",
          op_ret[k], op_iss[k] + eff_lat(op_lat[k]));
      chk(op_iss[k] >= op_disp[k] + 2, "R3 random gap", op_iss[k], op_disp[k] + 2);
      chk(busy_log[(op_iss[k] - 1) % 4096][op_igrp[k]*NU + op_unit[k]] == 0,
          "R6 random grant on free unit", 1, 0);
      chk(op_igrp[k] == op_grp[k], "R4 random group", op_igrp[k], op_grp[k]);
      for (int j = k + 1; j < n_ops; j++) begin
        if (op_grp[j] == op_grp[k]) begin
          chk(op_iss[j] > op_iss[k], "R4 random oldest-first order", op_iss[j], op_iss[k] + 1);
          break;
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule